// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the integer arithmetic and Boolean core of an execution pipeline. Each cycle it accepts two operands of configurable width, the current flag word and an operation code. One clock edge later it presents a result, a new six-bit flag word and a write-enable.

The operations are:

- Arithmetic: add, subtract, add-with-carry, subtract-with-borrow, increment, decrement and two's complement negate.
- Bitwise: AND, OR, XOR and NOT.
- Flag-only: compare and test, which set flags but do not write a result.

Every operation has its own policy for which flags it rewrites. Flags that an operation does not own are copied from the flag input. This lets a sequence of add-with-carry or subtract-with-borrow steps carry a borrow or carry from word to word, even when increment, decrement or NOT operations are placed between them.

The flag word is laid out with:

- bit 0 = carry
- bit 1 = parity
- bit 2 = auxiliary carry
- bit 3 = zero
- bit 4 = sign
- bit 5 = overflow

The incoming carry used by the chained operations is bit 0 of the flag input. Operation codes are:

| Code | Operation |
|---|---|
| 0 | add |
| 1 | subtract |
| 2 | add-with-carry |
| 3 | subtract-with-borrow |
| 4 | increment |
| 5 | decrement |
| 6 | negate |
| 7 | AND |
| 8 | OR |
| 9 | XOR |
| 10 | NOT |
| 11 | compare |
| 12 | test |

Codes 13 to 15 are unassigned. The width must be at least 8.

Top module: `ialu_flags`

## Requirements
- R1: All outputs are registered: a request presented before a rising edge appears on result_o, flags_o and wr_en_o after that edge. A synchronous active-high rst clears result_o, flags_o and wr_en_o to zero.
- R2: For add (code 0), carry (flag bit 0) is the unsigned carry out of the top bit. For subtract (code 1), carry is set exactly when a_i is unsigned-less-than b_i.
- R3: Overflow (flag bit 5) marks signed overflow for the arithmetic operations. The largest positive value plus one gives the most negative value with overflow 1 and carry 0. All-ones plus one gives zero with carry 1 and overflow 0.
- R4: Add-with-carry (code 2) yields a_i+b_i+flags_i[0], and subtract-with-borrow (code 3) yields a_i-b_i-flags_i[0]. Both set every flag, so chained words propagate carry or borrow.
- R5: Increment (code 4) and decrement (code 5) yield a_i+1 and a_i-1. They update overflow, sign, zero, auxiliary and parity, and pass flags_i[0] through to carry.
- R6: Negate (code 6) yields 0-a_i. Carry is 0 only for a zero operand. Overflow is set only for the most negative operand, whose negation equals itself.
- R7: Parity (flag bit 1) is 1 when the low 8 bits of the computed value hold an even number of ones. For arithmetic, the auxiliary flag (bit 2) is the carry, or borrow, between bit 3 and bit 4.
- R8: Zero (flag bit 3) is set when the computed value is all zeros. Sign (flag bit 4) equals its top bit.
- R9: AND, OR and XOR (codes 7, 8 and 9) write the bitwise result. They force carry, overflow and auxiliary to 0, and set zero, sign and parity from the result.
- R10: NOT (code 10) writes the bitwise inverse of a_i and passes all six flags from flags_i unchanged.
- R11: Compare (code 11) sets all flags exactly as subtract does, and test (code 12) sets flags exactly as AND does. Both drive wr_en_o low, while result_o shows the computed value. Every other defined operation drives wr_en_o high.
- R12: Unassigned codes 13 to 15 present a_i on result_o, pass flags_i unchanged and drive wr_en_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| flags_i | input | 6 | Current flag word; bit 0 is the incoming carry |
| result_o | output | W | Registered result value |
| flags_o | output | 6 | Registered new flag word |
| wr_en_o | output | 1 | Registered write-enable for the result |

## Verification
The hardest states to reach are the policy corners, where an old flag must survive next to freshly computed ones. Examples are an increment or decrement that wraps while the incoming carry is set or clear, and a NOT or unassigned code that must return a flag word it never computed.

The stimulus reaches these states by presenting distinctive flag-input patterns such as 0x2A, 0x3F and 0x15 together with operands at the wrap points (all-ones, the most negative value, zero). This way, any recomputed flag differs from the passed-through one.

A two-word add-with-carry and a subtract-with-borrow step check that the carry input really enters the sum.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADDC = 4'd2,
    OP_SUBB = 4'd3,
    OP_INCR = 4'd4,
    OP_DECR = 4'd5,
    OP_NEGT = 4'd6,
    OP_AND  = 4'd7,
    OP_OR   = 4'd8,
    OP_XOR  = 4'd9,
    OP_NOT  = 4'd10,
    OP_CMP  = 4'd11,
    OP_TST  = 4'd12
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;

  // packed MSB first: ovf is bit 5, cry is bit 0
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } flags_t;

  localparam int FLAG_W = 6;

endpackage

// File: rtl/ialu_addsub.sv
module ialu_addsub #(
  parameter int W = 64
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cry_o,
  output logic         aux_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] y_eff;
  logic         c_eff;
  logic         c_out;
  logic         c_nib;

  // subtraction runs as x + ~y + ~borrow; carry sense is inverted afterwards
  assign y_eff = sub_i ? ~y_i : y_i;
  assign c_eff = sub_i ? ~cin_i : cin_i;
  assign {c_out, sum_o} = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, c_eff};

  assign c_nib = x_i[4] ^ y_eff[4] ^ sum_o[4];
  assign cry_o = sub_i ? ~c_out : c_out;
  assign aux_o = sub_i ? ~c_nib : c_nib;
  assign ovf_o = (x_i[MSB] == y_eff[MSB]) && (sum_o[MSB] != x_i[MSB]);

endmodule

// File: rtl/ialu_logic.sv
module ialu_logic #(
  parameter int W = 64
) (
  input  logic [W-1:0]              a_i,
  input  logic [W-1:0]              b_i,
  input  ialu_pkg::logic_sel_e      sel_i,
  output logic [W-1:0]              res_o
);
  always_comb begin
    unique case (sel_i)
      ialu_pkg::LG_OR:  res_o = a_i | b_i;
      ialu_pkg::LG_XOR: res_o = a_i ^ b_i;
      default:          res_o = a_i & b_i;
    endcase
  end
endmodule

// File: rtl/ialu_flaggen.sv
module ialu_flaggen #(
  parameter int W     = 64,
  parameter int PAR_W = 8
) (
  input  logic [W-1:0] val_i,
  output logic         par_o,
  output logic         zro_o,
  output logic         sgn_o
);
  localparam int MSB = W - 1;

  // parity folded bit by bit over the low byte
  logic [PAR_W:0] par_chain;
  assign par_chain[0] = 1'b1;
  for (genvar i = 0; i < PAR_W; i++) begin : g_par
    assign par_chain[i+1] = par_chain[i] ^ val_i[i];
  end

  assign par_o = par_chain[PAR_W];
  assign zro_o = (val_i == '0);
  assign sgn_o = val_i[MSB];

endmodule

// File: rtl/ialu_flags.sv
module ialu_flags #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [5:0]   flags_i,
  output logic [W-1:0] result_o,
  output logic [5:0]   flags_o,
  output logic         wr_en_o
);
  import ialu_pkg::*;

  alu_op_e      op;
  flags_t       f_in;
  flags_t       f_nxt;
  logic [W-1:0] res_nxt;
  logic         we_nxt;

  logic [W-1:0] ax, ay;
  logic         acin, asub;
  logic [W-1:0] asum;
  logic         acry, aaux, aovf;

  logic_sel_e   lsel;
  logic [W-1:0] lres;

  logic [W-1:0] fsrc;
  logic         fpar, fzro, fsgn;

  assign op   = alu_op_e'(op_i);
  assign f_in = flags_t'(flags_i);

  // operand steering for the shared adder
  always_comb begin
    ax   = a_i;
    ay   = b_i;
    acin = 1'b0;
    asub = 1'b0;
    unique case (op)
      OP_SUB, OP_CMP: asub = 1'b1;
      OP_ADDC:        acin = f_in.cry;
      OP_SUBB: begin
        asub = 1'b1;
        acin = f_in.cry;
      end
      OP_INCR:        ay = {{(W-1){1'b0}}, 1'b1};
      OP_DECR: begin
        ay   = {{(W-1){1'b0}}, 1'b1};
        asub = 1'b1;
      end
      OP_NEGT: begin
        ax   = '0;
        ay   = a_i;
        asub = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (op)
      OP_OR:   lsel = LG_OR;
      OP_XOR:  lsel = LG_XOR;
      default: lsel = LG_AND;
    endcase
  end

  ialu_addsub #(.W(W)) u_addsub (
    .x_i   (ax),
    .y_i   (ay),
    .cin_i (acin),
    .sub_i (asub),
    .sum_o (asum),
    .cry_o (acry),
    .aux_o (aaux),
    .ovf_o (aovf)
  );

  ialu_logic #(.W(W)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (lsel),
    .res_o (lres)
  );

  // flag source: Boolean value for logic ops, adder sum otherwise
  always_comb begin
    unique case (op)
      OP_AND, OP_OR, OP_XOR, OP_TST: fsrc = lres;
      default:                       fsrc = asum;
    endcase
  end

  ialu_flaggen #(.W(W), .PAR_W(8)) u_flaggen (
    .val_i (fsrc),
    .par_o (fpar),
    .zro_o (fzro),
    .sgn_o (fsgn)
  );

  // per-operation flag policy and write-enable
  always_comb begin
    f_nxt   = f_in;
    res_nxt = a_i;
    we_nxt  = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB, OP_ADDC, OP_SUBB, OP_NEGT, OP_CMP: begin
        res_nxt = asum;
        we_nxt  = (op != OP_CMP);
        f_nxt   = '{ovf: aovf, sgn: fsgn, zro: fzro, aux: aaux,
                    par: fpar, cry: acry};
      end
      OP_INCR, OP_DECR: begin
        res_nxt = asum;
        we_nxt  = 1'b1;
        f_nxt   = '{ovf: aovf, sgn: fsgn, zro: fzro, aux: aaux,
                    par: fpar, cry: f_in.cry};
      end
      OP_AND, OP_OR, OP_XOR, OP_TST: begin
        res_nxt = lres;
        we_nxt  = (op != OP_TST);
        f_nxt   = '{ovf: 1'b0, sgn: fsgn, zro: fzro, aux: 1'b0,
                    par: fpar, cry: 1'b0};
      end
      OP_NOT: begin
        res_nxt = ~a_i;
        we_nxt  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      flags_o  <= '0;
      wr_en_o  <= 1'b0;
    end else begin
      result_o <= res_nxt;
      flags_o  <= f_nxt;
      wr_en_o  <= we_nxt;
    end
  end

endmodule

// File: rtl/ialu_flags_chk.sv
module ialu_flags_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [5:0]   flags_i,
  input logic [W-1:0] result_o,
  input logic [5:0]   flags_o,
  input logic         wr_en_o
);
  import ialu_pkg::*;

  logic is_logic, is_zchk;
  assign is_logic = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR) || (op_i == OP_TST);
  assign is_zchk  = (op_i == OP_ADD) || (op_i == OP_SUB) || (op_i == OP_AND) ||
                    (op_i == OP_OR)  || (op_i == OP_XOR);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (result_o == '0 && flags_o == '0 && !wr_en_o)); // R1

  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ADD) |=> flags_o[0] == ($past(a_i) > ~$past(b_i))); // R2

  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SUB) |=> flags_o[0] == ($past(a_i) < $past(b_i))); // R2

  AST_INCDEC_KEEP_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_INCR || op_i == OP_DECR) |=> flags_o[0] == $past(flags_i[0])); // R5

  AST_NEG_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_NEGT) |=> flags_o[0] == ($past(a_i) != '0)); // R6

  AST_PARITY_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
    is_zchk |=> flags_o[1] == ~^result_o[7:0]); // R7

  AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (rst)
    is_zchk |=> (flags_o[3] == (result_o == '0)) && (flags_o[4] == result_o[W-1])); // R8

  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    is_logic |=> (!flags_o[0] && !flags_o[5] && !flags_o[2])); // R9

  AST_AND_VALUE: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_AND) |=> result_o == ($past(a_i) & $past(b_i))); // R9

  AST_NOT_PASSES_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_NOT) |=> (flags_o == $past(flags_i)) && (result_o == ~$past(a_i))); // R10

  AST_NO_WRITE_CMP_TST: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CMP || op_i == OP_TST) |=> !wr_en_o); // R11

  AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (rst)
    (op_i > OP_TST) |=> (!wr_en_o && flags_o == $past(flags_i) && result_o == $past(a_i))); // R12

endmodule

bind ialu_flags ialu_flags_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .flags_i  (flags_i),
  .result_o (result_o),
  .flags_o  (flags_o),
  .wr_en_o  (wr_en_o)
);

// File: tb/ialu_flags_bench.sv
module ialu_flags_bench;
  import ialu_pkg::*;

  localparam int W = 64;
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op_i = '0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic [5:0]   flags_i = '0;
  logic [W-1:0] result_o;
  logic [5:0]   flags_o;
  logic         wr_en_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ialu_flags #(.W(W)) u_ialu_flags (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .flags_i  (flags_i),
    .result_o (result_o),
    .flags_o  (flags_o),
    .wr_en_o  (wr_en_o)
  );

  task automatic apply(input logic [3:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [5:0] f);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; flags_i = f;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [W-1:0] er,
                       input logic [5:0] ef, input logic ew);
    checks++;
    if (result_o !== er || flags_o !== ef || wr_en_o !== ew) begin
      fails++;
      $display("FAIL %s: result=%h flags=%h we=%b expected result=%h flags=%h we=%b",
               req, result_o, flags_o, wr_en_o, er, ef, ew);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1 reset", '0, 6'h00, 1'b0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_add();
    apply(OP_ADD, SMAX, 1, 6'h00);
    check("R3 max+1", SMIN, 6'h36, 1'b1);
    apply(OP_ADD, ONES, 1, 6'h00);
    check("R2 R3 ones+1", '0, 6'h0F, 1'b1);
  endtask

  task automatic t_sub();
    apply(OP_SUB, 5, 7, 6'h00);
    check("R2 R7 5-7 borrow", ONES - 1, 6'h15, 1'b1);
  endtask

  task automatic t_chain();
    apply(OP_ADDC, ONES, 0, 6'h01);
    check("R4 adc low word", '0, 6'h0F, 1'b1);
    apply(OP_ADDC, 1, 0, 6'h01);
    check("R4 adc high word", 2, 6'h00, 1'b1);
    apply(OP_SUBB, 0, 0, 6'h01);
    check("R4 sbb 0-0-1", ONES, 6'h17, 1'b1);
  endtask

  task automatic t_incdec();
    apply(OP_INCR, ONES, 0, 6'h00);
    check("R5 inc wraps, carry kept 0", '0, 6'h0E, 1'b1);
    apply(OP_INCR, 64'h0F, 0, 6'h01);
    check("R5 R7 inc nibble carry, carry kept 1", 64'h10, 6'h05, 1'b1);
    apply(OP_DECR, SMIN, 0, 6'h3F);
    check("R5 R3 dec min", SMAX, 6'h27, 1'b1);
  endtask

  task automatic t_neg();
    apply(OP_NEGT, 0, 0, 6'h3F);
    check("R6 neg zero", '0, 6'h0A, 1'b1);
    apply(OP_NEGT, SMIN, 0, 6'h00);
    check("R6 neg min", SMIN, 6'h33, 1'b1);
    apply(OP_NEGT, 1, 0, 6'h00);
    check("R6 neg one", ONES, 6'h17, 1'b1);
  endtask

  task automatic t_logic();
    apply(OP_AND, 64'hFF00FF00FF00FF00, 64'h0F0F0F0F0F0F0F0F, 6'h3F);
    check("R9 and", 64'h0F000F000F000F00, 6'h02, 1'b1);
    apply(OP_OR, SMIN, 3, 6'h3F);
    check("R9 R8 or", SMIN | 3, 6'h12, 1'b1);
    apply(OP_XOR, 64'h1234, 64'h1234, 6'h21);
    check("R9 R8 xor zero", '0, 6'h0A, 1'b1);
  endtask

  task automatic t_not();
    apply(OP_NOT, 64'h0123456789ABCDEF, 0, 6'h2A);
    check("R10 not", 64'hFEDCBA9876543210, 6'h2A, 1'b1);
  endtask

  task automatic t_compare();
    apply(OP_CMP, 3, 3, 6'h00);
    check("R11 cmp equal", '0, 6'h0A, 1'b0);
    apply(OP_CMP, 1, 2, 6'h00);
    check("R11 R2 cmp below", ONES, 6'h17, 1'b0);
  endtask

  task automatic t_test();
    apply(OP_TST, 64'h10, 64'h30, 6'h3F);
    check("R11 R9 test nonzero", 64'h10, 6'h00, 1'b0);
    apply(OP_TST, 64'h10, 64'h01, 6'h3F);
    check("R11 test zero", '0, 6'h0A, 1'b0);
  endtask

  task automatic t_unused();
    for (int c = 13; c < 16; c++) begin
      apply(4'(c), 64'hA5, 64'h5A, 6'h15);
      check("R12 unassigned code", 64'hA5, 6'h15, 1'b0);
    end
  endtask

  task automatic t_mid_reset();
    apply(OP_ADD, ONES, 1, 6'h00);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1 reset mid-run", '0, 6'h00, 1'b0);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_chain();
    t_incdec();
    t_neg();
    t_logic();
    t_not();
    t_compare();
    t_test();
    t_unused();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule